// File: doc/BRIEF.md
# Bus-Request Memory Test Sequencer

This block borrows the memory bus of a running processor and runs a full write/read check of the RAM behind it. On a start pulse it first holds the processor in reset for a few clock cycles, then requests the bus. It waits until the processor grants the bus, and only then enables its own drivers. It walks every address in ascending order, with the upper half of the address as the outer loop and the lower half as the inner loop. Each location is written and then read back straight away.

The test byte begins at 0x55 and is inverted at every new address, so neighbouring cells always hold opposite bit patterns. Each mismatch produces one report on a valid/ready stream. The report carries the upper and lower address parts, the byte that was expected and the byte that came back. If a report is still waiting to be accepted when the next mismatch arrives, the walk pauses.

When the last address has been checked, the block turns off every bus driver. One cycle later it drops its bus request. It then raises `done` together with a pass flag and the number of cycles it owned the bus. These stay valid until the next start. The bus pins are plain outputs with enable signals, so the pad ring or the bench can build the tri-state drivers from them.

Top module: `mtest_seq`

## Requirements
- R1: A start pulse seen while idle drives `cpu_rst_n` low for exactly RST_CYC cycles. `busreq_n` stays high during that pulse and goes low in the cycle after it.
- R2: `bus_oe` and `d_oe` stay low until a low `busack_n` has passed through SYNC_STAGES register stages. While `bus_oe` is high, `busreq_n` is low.
- R3: Written addresses run from 0 to 2^ADDR_W-1 in ascending order, once each. The upper ADDR_W/2 bits form the outer loop and the lower bits the inner loop.
- R4: The byte written to address 0 is SEED (default 0x55). The byte written to each following address is the bitwise complement of the byte written before it.
- R5: A write cycle takes MREQ low for one cycle, then WR low for STB_CYC cycles. WR is raised while MREQ is still low, and MREQ is raised after that. `d_oe` is high only while MREQ is low in a write cycle.
- R6: A read cycle takes MREQ low for one cycle, then RD low for STB_CYC cycles. The data is sampled on the last RD-low edge. RD is raised before MREQ. `d_oe` is low for the whole read, and RD and WR are never low at the same time.
- R7: Every address is read back directly after its own write, before the address changes.
- R8: Every mismatch produces one report, in address order, with `err_hi`/`err_lo` = address halves, `err_exp` = written byte and `err_got` = byte read. `err_valid` and the fields stay stable until `err_ready` is sampled high.
- R9: A mismatch found while an earlier report is still unaccepted stalls the walk. The new report is loaded in the same cycle the old one is accepted, and no report is lost.
- R10: After the last address, the block clears `bus_oe` and `d_oe`. In the next cycle it raises `busreq_n` and `done`. `pass` is high only if no mismatch was seen.
- R11: `elapsed` equals the number of cycles `bus_oe` was high. With no stalls this is 2^ADDR_W * (2*STB_CYC+6).
- R12: `done`, `pass` and `elapsed` hold until the next start. A start pulse during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (used only when idle) |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | No mismatch seen in the last run |
| elapsed | output | CNT_W | Cycles the bus was owned in the last run |
| cpu_rst_n | output | 1 | Processor reset, active low |
| busreq_n | output | 1 | Bus request, active low |
| busack_n | input | 1 | Bus grant from the processor, active low, asynchronous |
| bus_oe | output | 1 | Output enable for address and strobes |
| addr | output | ADDR_W | Memory address |
| mreq_n | output | 1 | Memory request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| d_oe | output | 1 | Data bus output enable |
| d_o | output | DATA_W | Data driven during writes |
| d_i | input | DATA_W | Data bus as seen by the block |
| err_valid | output | 1 | Mismatch report valid |
| err_ready | input | 1 | Mismatch report accepted |
| err_hi | output | ADDR_W/2 | Upper address part of the failing cell |
| err_lo | output | ADDR_W-ADDR_W/2 | Lower address part of the failing cell |
| err_exp | output | DATA_W | Byte that was written |
| err_got | output | DATA_W | Byte that was read |

## Verification
The coincidence that matters is a new mismatch being found in the same cycle that the sink accepts the previous report. The report register then has to hand off the old entry and take the new one on a single edge. The bench sets this up by corrupting two adjacent cells and holding `err_ready` low longer than one address step, so the second comparison stalls and is released by the very ready pulse that retires the first report. It then checks that both reports arrive in order with their exact fields, that the walk resumed with no address skipped, and that `elapsed` grew by the stall cycles.

// File: rtl/mt_pkg.sv
package mt_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CRST,
      S_REQ,
      S_WMREQ,
      S_WSTB,
      S_WREL,
      S_GAP,
      S_RMREQ,
      S_RSTB,
      S_RREL,
      S_CHECK,
      S_RELEASE
   } mt_state_e;

   // states in which the sequencer owns and drives the memory bus
   function automatic logic mt_owns_bus(mt_state_e s);
      return s inside {S_WMREQ, S_WSTB, S_WREL, S_GAP,
                       S_RMREQ, S_RSTB, S_RREL, S_CHECK};
   endfunction

   // states in which the memory request strobe is active
   function automatic logic mt_mreq_active(mt_state_e s);
      return s inside {S_WMREQ, S_WSTB, S_WREL, S_RMREQ, S_RSTB, S_RREL};
   endfunction

   // states in which the bus request is held
   function automatic logic mt_req_active(mt_state_e s);
      return s inside {S_REQ, S_WMREQ, S_WSTB, S_WREL, S_GAP,
                       S_RMREQ, S_RSTB, S_RREL, S_CHECK, S_RELEASE};
   endfunction

endpackage

// File: rtl/mt_ack_sync.sv
module mt_ack_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_async,
   output logic ack_seen
);

   generate
      if (STAGES == 0) begin : g_direct
         assign ack_seen = ~ack_n_async;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= (sh << 1) | STAGES'(ack_n_async);
         end
         assign ack_seen = ~sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mt_addr_walk.sv
module mt_addr_walk #(
   parameter int unsigned HI_W   = 8,
   parameter int unsigned LO_W   = 8,
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] SEED = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic [HI_W-1:0]   hi,
   output logic [LO_W-1:0]   lo,
   output logic [DATA_W-1:0] pattern,
   output logic              last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo      <= '0;
         hi      <= '0;
         pattern <= SEED;
      end else if (clear) begin
         lo      <= '0;
         hi      <= '0;
         pattern <= SEED;
      end else if (step) begin
         lo      <= lo + 1'b1;
         if (&lo) hi <= hi + 1'b1;
         pattern <= ~pattern;
      end
   end

   assign last = (&lo) & (&hi);

endmodule

// File: rtl/mt_err_port.sv
module mt_err_port #(
   parameter int unsigned HI_W   = 8,
   parameter int unsigned LO_W   = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HI_W-1:0]   in_hi,
   input  logic [LO_W-1:0]   in_lo,
   input  logic [DATA_W-1:0] in_exp,
   input  logic [DATA_W-1:0] in_got,
   input  logic              ready,
   output logic              valid,
   output logic              busy,
   output logic [HI_W-1:0]   out_hi,
   output logic [LO_W-1:0]   out_lo,
   output logic [DATA_W-1:0] out_exp,
   output logic [DATA_W-1:0] out_got
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         out_hi  <= '0;
         out_lo  <= '0;
         out_exp <= '0;
         out_got <= '0;
      end else if (load) begin
         valid   <= 1'b1;
         out_hi  <= in_hi;
         out_lo  <= in_lo;
         out_exp <= in_exp;
         out_got <= in_got;
      end else if (valid && ready) begin
         valid   <= 1'b0;
      end
   end

   // a new entry fits when the slot is empty or is being emptied this cycle
   assign busy = valid & ~ready;

endmodule

// File: rtl/mt_span_cnt.sv
module mt_span_cnt #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         en,
   output logic [W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (clear)  count <= '0;
      else if (en)     count <= count + 1'b1;
   end

endmodule

// File: rtl/mtest_seq.sv
module mtest_seq
   import mt_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SEED        = 'h55,
   parameter int unsigned RST_CYC     = 4,
   parameter int unsigned STB_CYC     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   output logic                       done,
   output logic                       pass,
   output logic [CNT_W-1:0]           elapsed,
   output logic                       cpu_rst_n,
   output logic                       busreq_n,
   input  logic                       busack_n,
   output logic                       bus_oe,
   output logic [ADDR_W-1:0]          addr,
   output logic                       mreq_n,
   output logic                       rd_n,
   output logic                       wr_n,
   output logic                       d_oe,
   output logic [DATA_W-1:0]          d_o,
   input  logic [DATA_W-1:0]          d_i,
   output logic                       err_valid,
   input  logic                       err_ready,
   output logic [ADDR_W/2-1:0]        err_hi,
   output logic [ADDR_W-ADDR_W/2-1:0] err_lo,
   output logic [DATA_W-1:0]          err_exp,
   output logic [DATA_W-1:0]          err_got
);

   localparam int unsigned HI_W = ADDR_W / 2;
   localparam int unsigned LO_W = ADDR_W - HI_W;
   localparam int unsigned TMAX = (RST_CYC > STB_CYC) ? RST_CYC : STB_CYC;
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam logic [DATA_W-1:0] SEED_V = DATA_W'(SEED);
   localparam logic [TW-1:0] RST_LD = TW'(RST_CYC - 1);
   localparam logic [TW-1:0] STB_LD = TW'(STB_CYC - 1);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mtest_seq: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mtest_seq: DATA_W must be at least 1");
      end
      if (RST_CYC < 1 || STB_CYC < 1) begin : g_bad_cyc
         $error("mtest_seq: RST_CYC and STB_CYC must be at least 1");
      end
      if (CNT_W <= ADDR_W + $clog2(2 * STB_CYC + 6)) begin : g_bad_cnt
         $error("mtest_seq: CNT_W too narrow for a stall-free run");
      end
   endgenerate

   mt_state_e         state;
   logic [TW-1:0]     tick;
   logic [DATA_W-1:0] rd_q;
   logic              done_q;
   logic              err_seen;

   logic              ack_seen;
   logic [HI_W-1:0]   a_hi;
   logic [LO_W-1:0]   a_lo;
   logic [DATA_W-1:0] pattern;
   logic              last;
   logic              rep_busy;
   logic              mism;
   logic              advance;
   logic              walk_clr;
   logic              walk_step;
   logic              rep_load;
   logic              own;

   mt_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack_n_async (busack_n),
      .ack_seen    (ack_seen)
   );

   mt_addr_walk #(.HI_W(HI_W), .LO_W(LO_W), .DATA_W(DATA_W), .SEED(SEED_V)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (walk_clr),
      .step    (walk_step),
      .hi      (a_hi),
      .lo      (a_lo),
      .pattern (pattern),
      .last    (last)
   );

   mt_err_port #(.HI_W(HI_W), .LO_W(LO_W), .DATA_W(DATA_W)) u_rep (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (rep_load),
      .in_hi   (a_hi),
      .in_lo   (a_lo),
      .in_exp  (pattern),
      .in_got  (rd_q),
      .ready   (err_ready),
      .valid   (err_valid),
      .busy    (rep_busy),
      .out_hi  (err_hi),
      .out_lo  (err_lo),
      .out_exp (err_exp),
      .out_got (err_got)
   );

   mt_span_cnt #(.W(CNT_W)) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (walk_clr),
      .en    (own),
      .count (elapsed)
   );

   assign mism      = (rd_q != pattern);
   assign advance   = ~(mism & rep_busy);
   assign walk_clr  = (state == S_IDLE) & start;
   assign walk_step = (state == S_CHECK) & advance & ~last;
   assign rep_load  = (state == S_CHECK) & mism & advance;
   assign own       = mt_owns_bus(state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         tick     <= '0;
         rd_q     <= '0;
         done_q   <= 1'b0;
         err_seen <= 1'b0;
      end else begin
         case (state)
            S_IDLE: begin
               if (start) begin
                  state    <= S_CRST;
                  tick     <= RST_LD;
                  done_q   <= 1'b0;
                  err_seen <= 1'b0;
               end
            end
            S_CRST: begin
               if (tick == '0) state <= S_REQ;
               else            tick  <= tick - 1'b1;
            end
            S_REQ: begin
               if (ack_seen) state <= S_WMREQ;
            end
            S_WMREQ: begin
               state <= S_WSTB;
               tick  <= STB_LD;
            end
            S_WSTB: begin
               if (tick == '0) state <= S_WREL;
               else            tick  <= tick - 1'b1;
            end
            S_WREL:  state <= S_GAP;
            S_GAP:   state <= S_RMREQ;
            S_RMREQ: begin
               state <= S_RSTB;
               tick  <= STB_LD;
            end
            S_RSTB: begin
               if (tick == '0) begin
                  rd_q  <= d_i;
                  state <= S_RREL;
               end else begin
                  tick  <= tick - 1'b1;
               end
            end
            S_RREL:  state <= S_CHECK;
            S_CHECK: begin
               if (advance) begin
                  if (mism) err_seen <= 1'b1;
                  state <= last ? S_RELEASE : S_WMREQ;
               end
            end
            S_RELEASE: begin
               state  <= S_IDLE;
               done_q <= 1'b1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // pin decode
   assign cpu_rst_n = (state != S_CRST);
   assign busreq_n  = ~mt_req_active(state);
   assign bus_oe    = own;
   assign addr      = {a_hi, a_lo};
   assign mreq_n    = ~mt_mreq_active(state);
   assign wr_n      = (state != S_WSTB);
   assign rd_n      = (state != S_RSTB);
   assign d_oe      = state inside {S_WMREQ, S_WSTB, S_WREL};
   assign d_o       = pattern;
   assign done      = done_q;
   assign pass      = done_q & ~err_seen;

endmodule

// File: rtl/mt_seq_chk.sv
module mt_seq_chk #(
   parameter int unsigned HI_W   = 8,
   parameter int unsigned LO_W   = 8,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rst_n,
   input logic              busreq_n,
   input logic              bus_oe,
   input logic              mreq_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic              d_oe,
   input logic              done,
   input logic              err_valid,
   input logic              err_ready,
   input logic [HI_W-1:0]   err_hi,
   input logic [LO_W-1:0]   err_lo,
   input logic [DATA_W-1:0] err_exp,
   input logic [DATA_W-1:0] err_got
);

   a_r1_reset_before_request: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rst_n |-> (busreq_n && !bus_oe));

   a_r2_own_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !busreq_n);

   a_r5_write_inside_mreq: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (!mreq_n && d_oe));

   a_r5_drive_only_in_mreq: assert property (@(posedge clk) disable iff (!rst_n)
      d_oe |-> (!mreq_n && bus_oe));

   a_r6_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (!mreq_n && !d_oe && wr_n));

   a_r8_report_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !err_ready) |=> (err_valid && $stable(err_hi) && $stable(err_lo)
                                     && $stable(err_exp) && $stable(err_got)));

   a_r10_tristate_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busreq_n) |-> (!bus_oe && !$past(bus_oe)));

   a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busreq_n && !bus_oe && cpu_rst_n));

endmodule

bind mtest_seq mt_seq_chk #(
   .HI_W   (ADDR_W / 2),
   .LO_W   (ADDR_W - ADDR_W / 2),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_rst_n (cpu_rst_n),
   .busreq_n  (busreq_n),
   .bus_oe    (bus_oe),
   .mreq_n    (mreq_n),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .d_oe      (d_oe),
   .done      (done),
   .err_valid (err_valid),
   .err_ready (err_ready),
   .err_hi    (err_hi),
   .err_lo    (err_lo),
   .err_exp   (err_exp),
   .err_got   (err_got)
);

// File: tb/sim_mtest_seq.sv
module sim_mtest_seq;

   localparam int AW    = 8;
   localparam int DW    = 8;
   localparam int RC    = 3;
   localparam int SC    = 2;
   localparam int NADDR = 1 << AW;
   localparam int PER   = 2 * SC + 6;
   localparam int HOLD  = 15;

   typedef struct packed {
      logic [7:0] ack_dly;
      logic       slow;
      logic [1:0] nflt;
      logic [7:0] fa;
      logic [7:0] ma;
      logic [7:0] fb;
      logic [7:0] mb;
      logic       stall;
      logic       mid_start;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VEC [NV] = '{
      '{8'd3,  1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
      '{8'd1,  1'b0, 2'd2, 8'h00, 8'h01, 8'hFF, 8'h80, 1'b0, 1'b1},
      '{8'd20, 1'b1, 2'd2, 8'h12, 8'hFF, 8'h13, 8'h0F, 1'b1, 1'b0},
      '{8'd0,  1'b1, 2'd1, 8'h80, 8'h55, 8'h00, 8'h00, 1'b0, 1'b0},
      '{8'd40, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          done, pass;
   logic [31:0]   elapsed;
   logic          cpu_rst_n, busreq_n, bus_oe;
   logic          busack_n = 1'b1;
   logic [AW-1:0] addr;
   logic          mreq_n, rd_n, wr_n, d_oe;
   logic [DW-1:0] d_o, d_i;
   logic          err_valid;
   logic          err_ready = 1'b1;
   logic [3:0]    err_hi, err_lo;
   logic [DW-1:0] err_exp, err_got;

   always #2 clk = ~clk;

   mtest_seq #(
      .ADDR_W(AW), .DATA_W(DW), .SEED('h55), .RST_CYC(RC),
      .STB_CYC(SC), .SYNC_STAGES(2), .CNT_W(32)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
      .elapsed(elapsed), .cpu_rst_n(cpu_rst_n), .busreq_n(busreq_n),
      .busack_n(busack_n), .bus_oe(bus_oe), .addr(addr), .mreq_n(mreq_n),
      .rd_n(rd_n), .wr_n(wr_n), .d_oe(d_oe), .d_o(d_o), .d_i(d_i),
      .err_valid(err_valid), .err_ready(err_ready), .err_hi(err_hi),
      .err_lo(err_lo), .err_exp(err_exp), .err_got(err_got)
   );

   // current scenario, written only by the main process
   vec_t cur = '0;

   function automatic logic [7:0] fmask(logic [7:0] a);
      if (cur.nflt > 0 && a == cur.fa) return cur.ma;
      if (cur.nflt > 1 && a == cur.fb) return cur.mb;
      return 8'h00;
   endfunction

   function automatic logic [7:0] pat_of(int a);
      return (a % 2 == 0) ? 8'h55 : 8'hAA;
   endfunction

   // RAM model: a faulty cell returns a corrupted byte when read
   logic [7:0] mem [NADDR];
   assign d_i = (!rd_n && !mreq_n) ? (mem[addr] ^ fmask(addr)) : 8'hFF;

   // ---------------- monitors (sample on the falling edge) ----------------
   int n_rst_low = 0, n_wr = 0, n_rd = 0, n_own = 0;
   int v_rst = 0, v_pre = 0, v_order = 0, v_pat = 0, v_w = 0, v_r = 0, v_raw = 0, v_rel = 0;
   int exp_wa = 0, last_wa = -1;
   logic prev_wr = 1'b1, prev_rd = 1'b1, prev_oe = 1'b0;
   int rep_n = 0;
   logic [7:0] rep_addr [32];
   logic [7:0] rep_exp  [32];
   logic [7:0] rep_got  [32];

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cpu_rst_n) begin
            n_rst_low++;
            exp_wa  = 0;
            last_wa = -1;
            if (!busreq_n) v_rst++;
         end
         if (bus_oe) n_own++;
         if ((bus_oe || d_oe) && busack_n) v_pre++;
         if (!wr_n && (mreq_n || !d_oe)) v_w++;
         if (d_oe && mreq_n) v_w++;
         if (!rd_n && (d_oe || !wr_n || mreq_n)) v_r++;
         if (!wr_n && prev_wr) begin
            n_wr++;
            if (int'(addr) != exp_wa) v_order++;
            if (d_o != pat_of(int'(addr))) v_pat++;
            mem[addr] = d_o;
            last_wa = int'(addr);
            exp_wa++;
         end
         if (!rd_n && prev_rd) begin
            n_rd++;
            if (int'(addr) != last_wa) v_raw++;
         end
         if (prev_oe && !bus_oe && busreq_n) v_rel++;
         if (err_valid && err_ready && rep_n < 32) begin
            rep_addr[rep_n] = {err_hi, err_lo};
            rep_exp[rep_n]  = err_exp;
            rep_got[rep_n]  = err_got;
            rep_n++;
         end
      end
      prev_wr = wr_n;
      prev_rd = rd_n;
      prev_oe = bus_oe;
   end

   // processor bus grant model
   initial begin
      int cnt = 0;
      forever begin
         @(posedge clk); #1;
         if (!busreq_n && cpu_rst_n) begin
            if (cnt >= int'(cur.ack_dly)) busack_n = 1'b0;
            cnt++;
         end else begin
            busack_n = 1'b1;
            cnt = 0;
         end
      end
   end

   // report sink: always ready, or ready for one cycle after HOLD cycles of valid
   initial begin
      int hold = 0;
      forever begin
         @(posedge clk); #1;
         if (!cur.slow) begin
            err_ready = 1'b1;
            hold = 0;
         end else if (err_valid && !err_ready) begin
            hold++;
            if (hold >= HOLD) begin
               err_ready = 1'b1;
               hold = 0;
            end
         end else begin
            err_ready = 1'b0;
            hold = 0;
         end
      end
   end

   // ---------------- checking ----------------
   int checks = 0, fails = 0;

   task automatic chk(input logic ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   int cyc = 0;
   always @(posedge clk) cyc++;

   initial begin
      wait (cyc > 150000);
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   task automatic run_vec(input int vi);
      int b_rst, b_wr, b_rd, b_own, b_rep;
      int b_vrst, b_vpre, b_vord, b_vpat, b_vw, b_vr, b_vraw, b_vrel;
      int nf, waited;
      logic [7:0] ea, eg, ee;
      logic [31:0] el;
      logic ps;
      cur = VEC[vi];
      for (int a = 0; a < NADDR; a++) mem[a] = 8'h00;
      b_rst = n_rst_low; b_wr = n_wr; b_rd = n_rd; b_own = n_own; b_rep = rep_n;
      b_vrst = v_rst; b_vpre = v_pre; b_vord = v_order; b_vpat = v_pat;
      b_vw = v_w; b_vr = v_r; b_vraw = v_raw; b_vrel = v_rel;
      nf = int'(cur.nflt);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      waited = 0;
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
         if (cur.mid_start && waited == 500) start = 1'b1;
         if (cur.mid_start && waited == 501) start = 1'b0;
      end
      chk(done, "R10", "done reached", done, 1);
      chk(pass == (nf == 0), "R10", "pass flag", pass, nf == 0);
      chk(busreq_n && !bus_oe && !d_oe, "R10", "bus released", {busreq_n, bus_oe, d_oe}, 3'b100);
      chk(v_rel == b_vrel, "R10", "drivers off before request drop", v_rel - b_vrel, 0);
      chk(n_rst_low - b_rst == RC, "R1", "cpu reset width", n_rst_low - b_rst, RC);
      chk(v_rst == b_vrst, "R1", "request during cpu reset", v_rst - b_vrst, 0);
      chk(v_pre == b_vpre, "R2", "drive without grant", v_pre - b_vpre, 0);
      chk(n_wr - b_wr == NADDR, "R3", "write count", n_wr - b_wr, NADDR);
      chk(v_order == b_vord, "R3", "address order", v_order - b_vord, 0);
      chk(v_pat == b_vpat, "R4", "write pattern", v_pat - b_vpat, 0);
      chk(v_w == b_vw, "R5", "write strobe shape", v_w - b_vw, 0);
      chk(v_r == b_vr, "R6", "read strobe shape", v_r - b_vr, 0);
      chk(n_rd - b_rd == NADDR && v_raw == b_vraw, "R7", "read after own write",
          v_raw - b_vraw, 0);
      // let a trailing report drain before counting
      repeat (HOLD + 4) @(negedge clk);
      chk(rep_n - b_rep == nf, "R8", "report count", rep_n - b_rep, nf);
      for (int k = 0; k < nf && k < rep_n - b_rep; k++) begin
         ea = (k == 0) ? cur.fa : cur.fb;
         ee = pat_of(int'(ea));
         eg = ee ^ ((k == 0) ? cur.ma : cur.mb);
         chk(rep_addr[b_rep+k] == ea, "R8", "report address", rep_addr[b_rep+k], ea);
         chk(rep_exp[b_rep+k] == ee && rep_got[b_rep+k] == eg, "R8", "report data",
             {rep_exp[b_rep+k], rep_got[b_rep+k]}, {ee, eg});
      end
      chk(elapsed == 32'(n_own - b_own), "R11", "elapsed vs owned cycles", elapsed, n_own - b_own);
      if (cur.stall)
         chk(elapsed > 32'(NADDR * PER), "R9", "walk stalled on pending report",
             elapsed, NADDR * PER + 1);
      else
         chk(elapsed == 32'(NADDR * PER), "R11", "stall-free elapsed", elapsed, NADDR * PER);
      el = elapsed; ps = pass;
      repeat (6) @(negedge clk);
      chk(done && pass == ps && elapsed == el, "R12", "results held while idle",
          {done, pass}, {1'b1, ps});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!done && busreq_n && !bus_oe && !d_oe && cpu_rst_n && !err_valid, "R10",
          "state in reset", {done, busreq_n, bus_oe, d_oe, cpu_rst_n, err_valid}, 6'b010010);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busreq_n && !bus_oe, "R2", "idle after reset", {busreq_n, bus_oe}, 2'b10);
      for (int vi = 0; vi < NV; vi++) run_vec(vi);
      // directed: grant withheld, bus must stay undriven (R2)
      cur = VEC[0];
      cur.ack_dly = 8'd60;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (RC + 40) @(negedge clk);
      chk(!busreq_n && !bus_oe && !d_oe && !done, "R2", "waits for grant",
          {busreq_n, bus_oe, d_oe}, 3'b000);
      // directed: reset mid-run returns everything to idle
      rst_n = 1'b0;
      @(negedge clk);
      chk(busreq_n && !bus_oe && !err_valid && !done, "R10", "reset mid-run",
          {busreq_n, bus_oe, err_valid, done}, 4'b1000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule